// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block derives CAN bit timing from the system clock. A prescaler divides the clock into time quanta. A segment sequencer walks every bit through a one-quantum synchronization slot, a first timing segment made of propagation time plus phase buffer one, and a second timing segment, phase buffer two. The receive line is read once per quantum. The block uses that reading to find falling (recessive-to-dominant) edges and to sample the bit value at the sample point.

When the frame logic reports an idle bus, the first falling edge hard-synchronizes the bit: the quantum that holds the edge becomes the synchronization slot. Inside a frame, an edge that arrives late lengthens phase buffer one. An edge that arrives early shortens phase buffer two, or closes the bit at once. The correction never exceeds the jump width, and only one correction is made per bit. The sampled value comes out with a one-cycle valid strobe. A separate one-cycle strobe marks each bit boundary. Frame decoding, arbitration, error counting and transmission belong to other blocks.

Top module: `can_bt_timing`

## Requirements
- R1: One quantum lasts 2*(cfgPresc+1) clock cycles. With no falling edge on rxIn, bitStart pulses for one cycle once per bit, and a bit is 1 + (cfgTseg1+1) + (cfgTseg2+1) quanta long.
- R2: While rstN is low, sampledBit is 1, sampleValid is 0 and bitStart is 0.
- R3: With cfgTriple = 0, the bit value is the rxIn level read at the last quantum of the first timing segment. sampleValid pulses in the cycle after that quantum ends, and sampledBit takes the value in that same cycle.
- R4: With cfgTriple = 1, sampledBit is the majority of the rxIn levels read at the sample-point quantum and at the two quanta before it.
- R5: While busIdle is 1, a falling edge restarts the bit. This applies in every segment. The edge quantum counts as the synchronization slot, so bitStart pulses after that quantum and the first timing segment follows.
- R6: With busIdle = 0, an edge seen at quantum e of the first timing segment (e = 1 for its first quantum) lengthens that segment by min(e, cfgSjw+1) quanta.
- R7: With busIdle = 0, an edge in the second timing segment is handled by r, the number of quanta left in the bit, counting the edge quantum itself. If r <= cfgSjw+1, the bit ends at the edge quantum, which becomes the next synchronization slot. Otherwise the segment is shortened by cfgSjw+1 quanta.
- R8: With busIdle = 0, an edge that falls in the synchronization slot has no effect on bit length.
- R9: After one resynchronization in a bit, further edges in the same bit have no effect.
- R10: An edge is a 1 read at one quantum followed by a 0 read at the next (1 = recessive, 0 = dominant). A rising transition never changes timing.
- R11: sampledBit changes only in a cycle where sampleValid is 1. sampleValid pulses at most once between two bitStart pulses and never in the same cycle as bitStart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIdle | input | 1 | Bus is idle; enables hard synchronization |
| rxIn | input | 1 | Receive line, 1 = recessive |
| cfgPresc | input | PRESC_W | Prescaler code; a quantum is 2*(code+1) clocks |
| cfgTseg1 | input | TSEG1_W | First timing segment length minus one (legal 3..15) |
| cfgTseg2 | input | TSEG2_W | Second timing segment length minus one (legal 1..7) |
| cfgSjw | input | SJW_W | Jump width minus one (legal 0..3, at most cfgTseg2) |
| cfgTriple | input | 1 | 1 = three-sample majority, 0 = single sample |
| sampledBit | output | 1 | Last sampled bit value |
| sampleValid | output | 1 | One-cycle strobe, new sampledBit |
| bitStart | output | 1 | One-cycle strobe at each bit boundary |

## Verification
The assertions check on every cycle that quantum pulses are spaced apart, that both strobes follow a quantum pulse, that the sampled bit holds between strobes, that at most one sample falls in each bit, and that no bit runs past its longest legal length. Each case needs a specific edge position in a specific segment, so only the bench's scenarios show the exact amount of each correction: lengthening, shortening, early close, a hard sync in the synchronization slot, an edge ignored in that slot, and a second edge ignored within one bit. The same holds for the value chosen by the majority vote.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  typedef struct packed {
    logic sampleNow;
    logic bitStart;
  } btStrobe_t;

endpackage

// File: rtl/can_bt_datapath.sv
module can_bt_datapath
  import can_bt_pkg::*;
#(
  parameter int PRESC_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxIn,
  input  logic [PRESC_W-1:0] cfgPresc,
  input  logic               cfgTriple,
  input  btStrobe_t          strobe,
  output logic               tqEn,
  output logic               rxEdge,
  output logic               sampledBit,
  output logic               sampleValid,
  output logic               bitStart
);

  localparam int PCNT_W = PRESC_W + 1;

  logic [PCNT_W-1:0] presCnt;
  logic [PCNT_W-1:0] presLimit;
  logic [1:0]        rxHist;
  logic              vote;
  logic              pick;

  // quantum is 2*(code+1) clocks: terminal count is 2*code+1
  assign presLimit = {cfgPresc, 1'b1};
  assign tqEn      = (presCnt == presLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      presCnt <= '0;
    else if (tqEn)  presCnt <= '0;
    else            presCnt <= presCnt + PCNT_W'(1);
  end

  // rxHist[0]: level at previous quantum, rxHist[1]: the one before
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rxHist <= 2'b11;
    else if (tqEn) rxHist <= {rxHist[0], rxIn};
  end

  assign rxEdge = tqEn & rxHist[0] & ~rxIn;

  assign vote = (rxHist[1] & rxHist[0]) | (rxHist[1] & rxIn) | (rxHist[0] & rxIn);
  assign pick = cfgTriple ? vote : rxIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampledBit  <= 1'b1;
      sampleValid <= 1'b0;
      bitStart    <= 1'b0;
    end else begin
      sampleValid <= strobe.sampleNow;
      bitStart    <= strobe.bitStart;
      if (strobe.sampleNow) sampledBit <= pick;
    end
  end

endmodule

// File: rtl/can_bt_control.sv
module can_bt_control
  import can_bt_pkg::*;
#(
  parameter int TSEG1_W = 4,
  parameter int TSEG2_W = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tqEn,
  input  logic               rxEdge,
  input  logic               busIdle,
  input  logic [TSEG1_W-1:0] cfgTseg1,
  input  logic [TSEG2_W-1:0] cfgTseg2,
  input  logic [SJW_W-1:0]   cfgSjw,
  output btStrobe_t          strobe
);

  localparam int CNT_W = TSEG1_W + 2;

  seg_e             seg, segN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [CNT_W-1:0] ph1Len, ph1N;
  logic [CNT_W-1:0] ph2Len, ph2N;
  logic             done, doneN;

  logic [CNT_W-1:0] base1, base2, sjwLen, cntP1, lateErr, earlyErr, ph2Short;

  assign base1    = CNT_W'(cfgTseg1) + CNT_W'(1);
  assign base2    = CNT_W'(cfgTseg2) + CNT_W'(1);
  assign sjwLen   = CNT_W'(cfgSjw) + CNT_W'(1);
  assign cntP1    = cnt + CNT_W'(1);
  assign lateErr  = (cntP1 < sjwLen) ? cntP1 : sjwLen;
  assign earlyErr = ph2Len - cnt;
  assign ph2Short = ph2Len - sjwLen;

  always_comb begin
    segN   = seg;
    cntN   = cnt;
    ph1N   = ph1Len;
    ph2N   = ph2Len;
    doneN  = done;
    strobe = '0;
    if (tqEn) begin
      if (rxEdge && busIdle) begin
        // hard sync: edge quantum acts as sync slot
        segN  = SEG_PH1;
        cntN  = '0;
        ph1N  = base1;
        ph2N  = base2;
        doneN = 1'b0;
        strobe.bitStart = 1'b1;
      end else if (rxEdge && !done && seg == SEG_PH1) begin
        ph1N  = ph1Len + lateErr;
        cntN  = cntP1;
        doneN = 1'b1;
      end else if (rxEdge && !done && seg == SEG_PH2) begin
        if (earlyErr <= sjwLen) begin
          segN  = SEG_PH1;
          cntN  = '0;
          ph1N  = base1;
          ph2N  = base2;
          doneN = 1'b0;
          strobe.bitStart = 1'b1;
        end else begin
          ph2N  = ph2Short;
          doneN = 1'b1;
          if (cntP1 == ph2Short) begin
            segN = SEG_SYNC;
            cntN = '0;
            strobe.bitStart = 1'b1;
          end else begin
            cntN = cntP1;
          end
        end
      end else begin
        case (seg)
          SEG_SYNC: begin
            segN  = SEG_PH1;
            cntN  = '0;
            ph1N  = base1;
            ph2N  = base2;
            doneN = 1'b0;
          end
          SEG_PH1: begin
            if (cntP1 == ph1Len) begin
              segN = SEG_PH2;
              cntN = '0;
              strobe.sampleNow = 1'b1;
            end else begin
              cntN = cntP1;
            end
          end
          SEG_PH2: begin
            if (cntP1 == ph2Len) begin
              segN = SEG_SYNC;
              cntN = '0;
              strobe.bitStart = 1'b1;
            end else begin
              cntN = cntP1;
            end
          end
          default: begin
            segN = SEG_SYNC;
            cntN = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg    <= SEG_SYNC;
      cnt    <= '0;
      ph1Len <= '0;
      ph2Len <= '0;
      done   <= 1'b0;
    end else begin
      seg    <= segN;
      cnt    <= cntN;
      ph1Len <= ph1N;
      ph2Len <= ph2N;
      done   <= doneN;
    end
  end

endmodule

// File: rtl/can_bt_timing.sv
module can_bt_timing
  import can_bt_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int TSEG1_W = 4,
  parameter int TSEG2_W = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busIdle,
  input  logic               rxIn,
  input  logic [PRESC_W-1:0] cfgPresc,
  input  logic [TSEG1_W-1:0] cfgTseg1,
  input  logic [TSEG2_W-1:0] cfgTseg2,
  input  logic [SJW_W-1:0]   cfgSjw,
  input  logic               cfgTriple,
  output logic               sampledBit,
  output logic               sampleValid,
  output logic               bitStart
);

  logic      tqEn;
  logic      rxEdge;
  btStrobe_t strobe;

  can_bt_datapath #(.PRESC_W(PRESC_W)) dp_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cfgPresc(cfgPresc),
    .cfgTriple(cfgTriple), .strobe(strobe), .tqEn(tqEn), .rxEdge(rxEdge),
    .sampledBit(sampledBit), .sampleValid(sampleValid), .bitStart(bitStart)
  );

  can_bt_control #(.TSEG1_W(TSEG1_W), .TSEG2_W(TSEG2_W), .SJW_W(SJW_W)) ctl_i (
    .clk(clk), .rstN(rstN), .tqEn(tqEn), .rxEdge(rxEdge), .busIdle(busIdle),
    .cfgTseg1(cfgTseg1), .cfgTseg2(cfgTseg2), .cfgSjw(cfgSjw), .strobe(strobe)
  );

endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker #(
  parameter int TSEG1_W = 4,
  parameter int TSEG2_W = 3,
  parameter int SJW_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               tqEn,
  input logic               bitStart,
  input logic               sampleValid,
  input logic               sampledBit,
  input logic [TSEG1_W-1:0] cfgTseg1,
  input logic [TSEG2_W-1:0] cfgTseg2,
  input logic [SJW_W-1:0]   cfgSjw
);

  logic [7:0] tqCount;
  logic [7:0] maxQ;
  logic       sampSeen;

  assign maxQ = 8'(cfgTseg1) + 8'(cfgTseg2) + 8'(cfgSjw) + 8'd4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tqCount  <= '0;
      sampSeen <= 1'b0;
    end else begin
      if (bitStart)          tqCount <= '0;
      else if (tqEn && tqCount != 8'hff) tqCount <= tqCount + 8'd1;
      if (bitStart)          sampSeen <= 1'b0;
      else if (sampleValid)  sampSeen <= 1'b1;
    end
  end

  AST_TQ_GAP: assert property (@(posedge clk) disable iff (!rstN)
    tqEn |=> !tqEn); // R1
  AST_BITSTART_AFTER_TQ: assert property (@(posedge clk) disable iff (!rstN)
    bitStart |-> $past(tqEn)); // R1
  AST_SAMPLE_AFTER_TQ: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(tqEn)); // R3
  AST_SAMPLE_NOT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> !bitStart); // R11
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampledBit)); // R11
  AST_ONE_SAMPLE_PER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> !sampSeen); // R11
  AST_BIT_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tqCount <= maxQ); // R6

endmodule

bind can_bt_timing can_bt_checker #(.TSEG1_W(TSEG1_W), .TSEG2_W(TSEG2_W), .SJW_W(SJW_W)) chk_i (
  .clk(clk), .rstN(rstN), .tqEn(tqEn), .bitStart(bitStart),
  .sampleValid(sampleValid), .sampledBit(sampledBit),
  .cfgTseg1(cfgTseg1), .cfgTseg2(cfgTseg2), .cfgSjw(cfgSjw)
);

// File: tb/can_bt_timing_tb.sv
module can_bt_timing_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busIdle = 1'b0;
  logic       rxIn = 1'b1;
  logic [5:0] cfgPresc = 6'd1;
  logic [3:0] cfgTseg1 = 4'd4;
  logic [2:0] cfgTseg2 = 3'd2;
  logic [1:0] cfgSjw = 2'd1;
  logic       cfgTriple = 1'b0;
  logic       sampledBit, sampleValid, bitStart;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  can_bt_timing dut_i (
    .clk(clk), .rstN(rstN), .busIdle(busIdle), .rxIn(rxIn),
    .cfgPresc(cfgPresc), .cfgTseg1(cfgTseg1), .cfgTseg2(cfgTseg2),
    .cfgSjw(cfgSjw), .cfgTriple(cfgTriple),
    .sampledBit(sampledBit), .sampleValid(sampleValid), .bitStart(bitStart)
  );

  // ---------------- behavioural reference ----------------
  int pc, pos, ext, shr, rPrev, rOld;
  bit mDone;
  int expBit = 1, expVal = 0, expStart = 0;

  function automatic int maj3(int a, int b, int c);
    return ((a + b + c) >= 2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pc = 0; pos = 0; ext = 0; shr = 0; mDone = 0;
      rPrev = 1; rOld = 1; expBit = 1; expVal = 0; expStart = 0;
    end else begin
      expVal = 0; expStart = 0;
      if (pc == 2 * int'(cfgPresc) + 1) begin
        int rx, l1, l2, sj, tot;
        bit edgeSeen, adv;
        pc = 0;
        rx = int'(rxIn); l1 = int'(cfgTseg1) + 1; l2 = int'(cfgTseg2) + 1;
        sj = int'(cfgSjw) + 1;
        tot = 1 + l1 + ext + l2 - shr;
        edgeSeen = (rPrev == 1) && (rx == 0);
        adv = 1;
        if (edgeSeen && busIdle) begin
          pos = 1; ext = 0; shr = 0; mDone = 0; expStart = 1; adv = 0;
        end else if (edgeSeen && !mDone && pos != 0) begin
          mDone = 1;
          if (pos <= l1 + ext) ext += (pos < sj) ? pos : sj;
          else if (tot - pos <= sj) begin
            pos = 1; ext = 0; shr = 0; mDone = 0; expStart = 1; adv = 0;
          end else shr += sj;
        end
        if (adv) begin
          tot = 1 + l1 + ext + l2 - shr;
          if (pos == l1 + ext) begin
            expVal = 1;
            expBit = cfgTriple ? maj3(rOld, rPrev, rx) : rx;
          end
          if (pos == tot - 1) begin
            pos = 0; ext = 0; shr = 0; mDone = 0; expStart = 1;
          end else pos++;
        end
        rOld = rPrev; rPrev = rx;
      end else pc++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total += 3;
      if (int'(bitStart) != expStart) begin
        bad++;
        $display("FAIL R1/R5/R6/R7/R8/R9/R10 bitStart cyc=%0d act=%0d exp=%0d", cyc, bitStart, expStart);
      end
      if (int'(sampleValid) != expVal) begin
        bad++;
        $display("FAIL R3/R11 sampleValid cyc=%0d act=%0d exp=%0d", cyc, sampleValid, expVal);
      end
      if (int'(sampledBit) != expBit) begin
        bad++;
        $display("FAIL R3/R4 sampledBit cyc=%0d act=%0d exp=%0d", cyc, sampledBit, expBit);
      end
    end
  end

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      report();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 reset sampledBit", int'(sampledBit), 1);
    check("R2 reset sampleValid", int'(sampleValid), 0);
    check("R2 reset bitStart", int'(bitStart), 0);
    rstN = 1'b1;
  endtask

  // clocks from one bitStart to the next, with falling edges at quanta j1, j2
  task automatic measureBit(input int j1, input int j2, output int n);
    int t;
    int g;
    t = 2 * (int'(cfgPresc) + 1);
    g = 0;
    @(negedge clk);
    while (!bitStart && g < 2000) begin @(negedge clk); g++; end
    rxIn = (j1 == 0) ? 1'b0 : 1'b1;
    n = -1;
    for (int k = 1; k <= 2000; k++) begin
      @(negedge clk);
      if (k == j1 * t && j1 > 0) rxIn = 1'b0;
      if (k == j1 * t + t && j1 >= 0) rxIn = 1'b1;
      if (k == j2 * t && j2 > 0) rxIn = 1'b0;
      if (k == j2 * t + t && j2 > 0) rxIn = 1'b1;
      if (bitStart) begin n = k; break; end
    end
    rxIn = 1'b1;
  endtask

  initial begin
    int n;
    // base config: tq = 4 clocks, TSEG1 5q, TSEG2 3q, SJW 2q, bit 9q
    doReset();
    measureBit(-1, -1, n); check("R1 nominal bit clocks", n, 36);
    measureBit(-1, -1, n); check("R1 nominal bit clocks again", n, 36);
    measureBit(0, -1, n);  check("R8 edge in sync slot", n, 36);
    measureBit(1, -1, n);  check("R6 late edge e=1", n, 40);
    measureBit(3, -1, n);  check("R6 late edge clipped to SJW", n, 44);
    measureBit(7, -1, n);  check("R7 early edge closes bit", n, 32);
    measureBit(6, -1, n);  check("R7 early edge shortens by SJW", n, 28);
    measureBit(1, 8, n);   check("R9 second edge ignored", n, 40);
    busIdle = 1'b1;
    measureBit(3, -1, n);  check("R5 hard sync mid-segment", n, 16);
    measureBit(0, -1, n);  check("R5 hard sync in sync slot", n, 4);
    busIdle = 1'b0;
    measureBit(-1, -1, n); check("R10 rising edge ignored", n, 36);

    // randomised runs across configurations, model compared every clock
    for (int c = 0; c < 3; c++) begin
      case (c)
        0: begin cfgPresc = 6'd0; cfgTseg1 = 4'd3;  cfgTseg2 = 3'd1; cfgSjw = 2'd1; cfgTriple = 1'b1; end
        1: begin cfgPresc = 6'd2; cfgTseg1 = 4'd15; cfgTseg2 = 3'd7; cfgSjw = 2'd3; cfgTriple = 1'b0; end
        default: begin cfgPresc = 6'd1; cfgTseg1 = 4'd6; cfgTseg2 = 3'd3; cfgSjw = 2'd2; cfgTriple = 1'b1; end
      endcase
      rxIn = 1'b1; busIdle = 1'b0;
      doReset();
      for (int k = 0; k < 6000; k++) begin
        @(negedge clk);
        if ($urandom_range(0, 6) == 0) rxIn = ~rxIn;
        if ($urandom_range(0, 300) == 0) busIdle = ~busIdle;
      end
    end
    report();
  end

endmodule